// File: doc/BRIEF.md
# Trace Output Region Table Walker

This block takes a byte stream of trace data and scatters it into memory through a chain of descriptor tables. Each 64-bit table entry either names one data region or links to another table. A data region has a page-aligned base and a power-of-two size. Three flag bits on each entry control linking, interrupts and halting. The walker reads entries over a request/response fetch port. It writes each accepted trace byte to memory as a single byte write, at the current region base plus the current offset.

Software programs three things: the address of the table to walk, a combined position word (entry index and byte offset), and an enable bit. It then watches three sticky status flags: stopped, error and lost. It also sees a one-cycle interrupt pulse. The trace input and the memory write port are valid/ready.

While the walker is streaming, the input's ready signal follows the memory port's ready signal, so back-pressure from memory passes straight through. While an entry is being fetched, the input is held off. While the block is disabled or halted, the input is always ready and bytes are thrown away. A value on a valid/ready interface must stay unchanged until its handshake completes.

Top module: `trace_region_walker`

## Requirements
- R1: After reset the block is disabled and idle. The stopped, error and lost flags are 0, `irq` is 0, and no fetch or write is requested. The position register reads 0x7F.
- R2: The position word carries the byte offset in bits 63:32 and the entry index in bits 31:7. Bits 6:0 always read as 1. Writes to the table base (select 1) and to the position (select 2) take effect only while enable is 0 and the walker is idle; at any other time they are ignored. Select 0 bit 0 is the enable.
- R3: Once enabled, and with no halt flag set, the walker fetches the entry at table base + 8 × index. The entry fields are: END at bit 0, INT at bit 2, STOP at bit 4, size order n in bits 9:6, and page number in bits 63:12. A region starts at the page number shifted left by PAGE_SHIFT and holds 2^(PAGE_SHIFT+n) bytes.
- R4: Each accepted byte is written to region base + offset, and the offset then increments by one. While streaming, `in_ready` equals `mem_wr_ready`. While a fetch is in progress and the block is enabled, `in_ready` is 0.
- R5: When a region without STOP fills, the offset returns to 0, the index increments by one, and the next entry is fetched.
- R6: An END entry loads its region address as the new table base and resets the index to 0, and walking continues. A chain that leads back to the first table forms a ring.
- R7: When a STOP region fills, the stopped flag is set and the walker halts. The offset is left equal to the region size, and the index is unchanged.
- R8: When an INT region fills, `irq` pulses high for exactly one cycle, in the cycle after the final byte's handshake. This happens whether or not STOP is also set on that entry.
- R9: The error flag is set and nothing is written if a fetched entry has any of these faults: END at index 0, a non-zero reserved bit (bits 1, 3, 5, 11:10), page bits beyond the address width, a region larger than 2^31 bytes, or a starting offset not below its region size.
- R10: A write to select 3 replaces the stopped, error and lost flags with data bits 0, 1 and 2. A hardware set in the same cycle wins. Once enabled and with stopped and error both clear, the walker restarts at the current position.
- R11: While the block is disabled or halted, input bytes are accepted, dropped and never written, and the sticky lost flag is set.
- R12: When enable is cleared, an entry fetch already in progress completes and its response is absorbed before `walker_idle` returns to 1. No write is issued after enable is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 table base, 2 position, 3 status |
| cfg_wdata | input | 64 | Register write data |
| trace_enable | output | 1 | Current enable bit |
| table_base | output | ADDR_W | Address of the table being walked |
| position | output | 64 | Offset, index and 0x7F word |
| stat_stopped | output | 1 | Sticky stopped flag |
| stat_error | output | 1 | Sticky error flag |
| stat_lost | output | 1 | Sticky lost-data flag |
| walker_idle | output | 1 | Walker is idle, with no fetch or write in progress |
| irq | output | 1 | One-cycle interrupt pulse |
| in_valid | input | 1 | Trace byte valid |
| in_ready | output | 1 | Trace byte accepted |
| in_byte | input | 8 | Trace byte |
| ent_req_valid | output | 1 | Entry fetch request |
| ent_req_ready | input | 1 | Entry fetch request accepted |
| ent_req_addr | output | ADDR_W | Entry address |
| ent_rsp_valid | input | 1 | Entry data returned |
| ent_rsp_data | input | 64 | Entry word |
| mem_wr_valid | output | 1 | Byte write request |
| mem_wr_ready | input | 1 | Byte write accepted |
| mem_wr_addr | output | ADDR_W | Byte write address |
| mem_wr_data | output | 8 | Byte write data |

## Verification
A two-table ring is streamed through fully: a 16-byte INT region, a 32-byte region under irregular memory back-pressure, a table link, and a link back to the start. This separates correct index stepping, link handling and address formation from ordering errors under stall. A STOP region entered at a mid-region offset shows that halting happens at the boundary, and that offered bytes afterwards are counted as lost rather than written. Each malformed entry kind, a disable while a fetch request is stalled, and a restart at a non-zero index and offset each check a single path: error detection, orderly drain, and the fetch address calculation.

// File: rtl/trw_pkg.sv
package trw_pkg;
  localparam int IDX_W    = 25;
  localparam int OFF_W    = 32;
  localparam int ENT_END  = 0;
  localparam int ENT_INT  = 2;
  localparam int ENT_STOP = 4;
  localparam int ORDER_LO = 6;
  localparam int PAGE_LO  = 12;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_BASE = 2'd1;
  localparam logic [1:0] SEL_POS  = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  typedef enum logic [1:0] {
    W_IDLE   = 2'd0,
    W_REQ    = 2'd1,
    W_WAIT   = 2'd2,
    W_STREAM = 2'd3
  } walk_state_t;
endpackage

// File: rtl/trw_entry_decode.sv
module trw_entry_decode
  import trw_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [63:0]       raw,
  output logic              is_end,
  output logic              want_irq,
  output logic              want_stop,
  output logic              malformed,
  output logic [ADDR_W-1:0] region_base,
  output logic [OFF_W:0]    region_size
);
  localparam int PG_W = ADDR_W - PAGE_SHIFT;

  logic [3:0]      order;
  logic [PG_W-1:0] page;
  logic [4:0]      reserved;
  logic            high_nz;
  logic            too_big;

  assign order       = raw[ORDER_LO +: 4];
  assign page        = raw[PAGE_LO +: PG_W];
  assign is_end      = raw[ENT_END];
  assign want_irq    = raw[ENT_INT];
  assign want_stop   = raw[ENT_STOP];
  assign reserved    = {raw[11:10], raw[5], raw[3], raw[1]};
  assign region_base = {page, {PAGE_SHIFT{1'b0}}};
  assign too_big     = (PAGE_SHIFT + int'(order)) >= OFF_W;
  assign region_size = (OFF_W+1)'(1) << (PAGE_SHIFT + int'(order));

  generate
    if (PAGE_LO + PG_W < 64) begin : g_high
      assign high_nz = |raw[63:PAGE_LO+PG_W];
    end else begin : g_nohigh
      assign high_nz = 1'b0;
    end
  endgenerate

  assign malformed = (|reserved) || high_nz || too_big;
endmodule

// File: rtl/trw_status.sv
module trw_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_we,
  input  logic [2:0] sw_data,
  input  logic       set_stop,
  input  logic       set_err,
  input  logic       set_lost,
  input  logic       fire_irq,
  output logic       stopped,
  output logic       error,
  output logic       lost,
  output logic       irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stopped <= 1'b0;
      error   <= 1'b0;
      lost    <= 1'b0;
      irq     <= 1'b0;
    end else begin
      stopped <= (sw_we ? sw_data[0] : stopped) | set_stop;
      error   <= (sw_we ? sw_data[1] : error)   | set_err;
      lost    <= (sw_we ? sw_data[2] : lost)    | set_lost;
      irq     <= fire_irq;
    end
  end
endmodule

// File: rtl/trw_walker.sv
module trw_walker
  import trw_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              halted,
  input  logic              cfg_base_we,
  input  logic              cfg_pos_we,
  input  logic [63:0]       cfg_wdata,
  output logic              ent_req_valid,
  input  logic              ent_req_ready,
  output logic [ADDR_W-1:0] ent_req_addr,
  input  logic              ent_rsp_valid,
  input  logic              dec_end,
  input  logic              dec_irq,
  input  logic              dec_stop,
  input  logic              dec_bad,
  input  logic [ADDR_W-1:0] dec_base,
  input  logic [OFF_W:0]    dec_size,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [7:0]        mem_wr_data,
  output logic [ADDR_W-1:0] table_base,
  output logic [IDX_W-1:0]  index,
  output logic [OFF_W-1:0]  offset,
  output logic              idle,
  output logic              ev_stop,
  output logic              ev_err,
  output logic              ev_irq,
  output logic              ev_lost
);
  walk_state_t       state_q;
  logic [ADDR_W-1:0] base_q, rbase_q;
  logic [IDX_W-1:0]  index_q;
  logic [OFF_W-1:0]  offset_q;
  logic [OFF_W:0]    rsize_q;
  logic              rint_q, rstop_q;
  logic              cfg_ok, dropping, streaming, wr_fire, at_end, rsp_live;

  always_comb begin
    cfg_ok        = !enable && (state_q == W_IDLE);
    dropping      = !enable || halted;
    streaming     = (state_q == W_STREAM) && !dropping;
    mem_wr_valid  = streaming && in_valid;
    in_ready      = dropping || (streaming && mem_wr_ready);
    wr_fire       = mem_wr_valid && mem_wr_ready;
    at_end        = ({1'b0, offset_q} + (OFF_W+1)'(1)) == rsize_q;
    rsp_live      = (state_q == W_WAIT) && ent_rsp_valid && !dropping;
    ev_err        = rsp_live && (dec_bad || (dec_end && index_q == '0) ||
                    (!dec_end && ({1'b0, offset_q} >= dec_size)));
    ev_irq        = wr_fire && at_end && rint_q;
    ev_stop       = wr_fire && at_end && rstop_q;
    ev_lost       = in_valid && dropping;
    ent_req_valid = (state_q == W_REQ);
    ent_req_addr  = base_q + ADDR_W'({index_q, 3'b000});
    mem_wr_addr   = rbase_q + ADDR_W'(offset_q);
    mem_wr_data   = in_byte;
    table_base    = base_q;
    index         = index_q;
    offset        = offset_q;
    idle          = (state_q == W_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= W_IDLE;
      base_q   <= '0;
      rbase_q  <= '0;
      index_q  <= '0;
      offset_q <= '0;
      rsize_q  <= '0;
      rint_q   <= 1'b0;
      rstop_q  <= 1'b0;
    end else begin
      if (cfg_ok && cfg_base_we) base_q <= {cfg_wdata[ADDR_W-1:3], 3'b000};
      if (cfg_ok && cfg_pos_we) begin
        index_q  <= cfg_wdata[7 +: IDX_W];
        offset_q <= cfg_wdata[63:32];
      end
      unique case (state_q)
        W_IDLE:   if (enable && !halted) state_q <= W_REQ;
        W_REQ:    if (ent_req_ready) state_q <= W_WAIT;
        W_WAIT: begin
          if (ent_rsp_valid) begin
            if (dropping || ev_err) begin
              state_q <= W_IDLE;
            end else if (dec_end) begin
              base_q  <= dec_base;
              index_q <= '0;
              state_q <= W_REQ;
            end else begin
              rbase_q <= dec_base;
              rsize_q <= dec_size;
              rint_q  <= dec_irq;
              rstop_q <= dec_stop;
              state_q <= W_STREAM;
            end
          end
        end
        W_STREAM: begin
          if (dropping) begin
            state_q <= W_IDLE;
          end else if (wr_fire) begin
            if (at_end && rstop_q) begin
              offset_q <= offset_q + 1'b1;
              state_q  <= W_IDLE;
            end else if (at_end) begin
              offset_q <= '0;
              index_q  <= index_q + 1'b1;
              state_q  <= W_REQ;
            end else begin
              offset_q <= offset_q + 1'b1;
            end
          end
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end

  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_req_valid && !ent_req_ready) |=> (ent_req_valid && $stable(ent_req_addr)));

  a_r4_offset_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == W_STREAM) |-> ({1'b0, offset_q} < rsize_q));

  a_r6_chain_resets_index: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_live && dec_end && !ev_err) |=> (index_q == '0 && state_q == W_REQ));
endmodule

// File: rtl/trace_region_walker.sv
module trace_region_walker
  import trw_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [63:0]       cfg_wdata,
  output logic              trace_enable,
  output logic [ADDR_W-1:0] table_base,
  output logic [63:0]       position,
  output logic              stat_stopped,
  output logic              stat_error,
  output logic              stat_lost,
  output logic              walker_idle,
  output logic              irq,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  output logic              ent_req_valid,
  input  logic              ent_req_ready,
  output logic [ADDR_W-1:0] ent_req_addr,
  input  logic              ent_rsp_valid,
  input  logic [63:0]       ent_rsp_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [7:0]        mem_wr_data
);
  logic              enable_q;
  logic              d_end, d_irq, d_stop, d_bad;
  logic [ADDR_W-1:0] d_base;
  logic [OFF_W:0]    d_size;
  logic [IDX_W-1:0]  cur_index;
  logic [OFF_W-1:0]  cur_offset;
  logic              e_stop, e_err, e_irq, e_lost;

  always_ff @(posedge clk) begin
    if (!rst_n)                              enable_q <= 1'b0;
    else if (cfg_we && cfg_sel == SEL_CTRL)  enable_q <= cfg_wdata[0];
  end

  assign trace_enable = enable_q;
  assign position     = {cur_offset, cur_index, 7'h7f};

  trw_entry_decode #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_dec (
    .raw(ent_rsp_data), .is_end(d_end), .want_irq(d_irq), .want_stop(d_stop),
    .malformed(d_bad), .region_base(d_base), .region_size(d_size)
  );

  trw_walker #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_walk (
    .clk(clk), .rst_n(rst_n), .enable(enable_q), .halted(stat_stopped || stat_error),
    .cfg_base_we(cfg_we && cfg_sel == SEL_BASE), .cfg_pos_we(cfg_we && cfg_sel == SEL_POS),
    .cfg_wdata(cfg_wdata),
    .ent_req_valid(ent_req_valid), .ent_req_ready(ent_req_ready), .ent_req_addr(ent_req_addr),
    .ent_rsp_valid(ent_rsp_valid),
    .dec_end(d_end), .dec_irq(d_irq), .dec_stop(d_stop), .dec_bad(d_bad),
    .dec_base(d_base), .dec_size(d_size),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .table_base(table_base), .index(cur_index), .offset(cur_offset), .idle(walker_idle),
    .ev_stop(e_stop), .ev_err(e_err), .ev_irq(e_irq), .ev_lost(e_lost)
  );

  trw_status u_stat (
    .clk(clk), .rst_n(rst_n), .sw_we(cfg_we && cfg_sel == SEL_STAT), .sw_data(cfg_wdata[2:0]),
    .set_stop(e_stop), .set_err(e_err), .set_lost(e_lost), .fire_irq(e_irq),
    .stopped(stat_stopped), .error(stat_error), .lost(stat_lost), .irq(irq)
  );

  a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r7_stop_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stat_stopped) && !$past(cfg_we && cfg_sel == SEL_STAT))
      |-> $past(mem_wr_valid && mem_wr_ready));

  a_r11_lost_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !trace_enable) |=> stat_lost);

  a_r12_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!trace_enable && $past(!trace_enable)) |-> !(mem_wr_valid && mem_wr_ready));
endmodule

// File: tb/tb_trace_region_walker.sv
`timescale 1ns/1ps
module tb_trace_region_walker;
  localparam int AW = 16;
  localparam int PS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [63:0]   cfg_wdata = '0;
  logic          trace_enable, stat_stopped, stat_error, stat_lost, walker_idle, irq;
  logic [AW-1:0] table_base, ent_req_addr, mem_wr_addr;
  logic [63:0]   position;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [7:0]    in_byte = '0;
  logic          ent_req_valid, mem_wr_valid;
  logic          ent_req_ready;
  logic          ent_rsp_valid = 1'b0;
  logic [63:0]   ent_rsp_data = '0;
  logic          mem_wr_ready = 1'b1;
  logic [7:0]    mem_wr_data;

  trace_region_walker #(.ADDR_W(AW), .PAGE_SHIFT(PS)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .trace_enable(trace_enable), .table_base(table_base), .position(position),
    .stat_stopped(stat_stopped), .stat_error(stat_error), .stat_lost(stat_lost),
    .walker_idle(walker_idle), .irq(irq),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .ent_req_valid(ent_req_valid), .ent_req_ready(ent_req_ready), .ent_req_addr(ent_req_addr),
    .ent_rsp_valid(ent_rsp_valid), .ent_rsp_data(ent_rsp_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  int total = 0;
  int bad = 0;
  int irq_cnt = 0;
  bit done = 0;
  bit bp_mode = 0;
  bit req_rdy = 1;
  int cyc = 0;
  logic [AW-1:0] last_req_addr = '0;
  logic [63:0] tbl [0:255];
  logic [23:0] exp_q [$];
  logic [7:0] seq = 8'h11;

  assign ent_req_ready = req_rdy;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    ent_rsp_valid <= ent_req_valid && ent_req_ready;
    ent_rsp_data  <= tbl[ent_req_addr[10:3]];
    if (ent_req_valid && ent_req_ready) last_req_addr <= ent_req_addr;
    cyc <= cyc + 1;
    mem_wr_ready <= !bp_mode || (cyc % 3 != 0);
  end

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (rst_n && mem_wr_valid && mem_wr_ready) begin
      if (exp_q.size() == 0) begin
        check("R11 unexpected write", {40'h0, mem_wr_addr, mem_wr_data}, 64'hDEAD);
      end else begin
        automatic logic [23:0] e = exp_q.pop_front();
        check("R4 write addr/data", {40'h0, mem_wr_addr, mem_wr_data}, {40'h0, e});
      end
    end
  end

  function automatic logic [63:0] ent(input int page, input int order,
                                      input bit e, input bit i, input bit s, input bit rsv);
    return (64'(page) << 12) | (64'(order) << 6) | (64'(s) << 4) |
           (64'(i) << 2) | 64'(e) | (rsv ? 64'h2 : 64'h0);
  endfunction

  function automatic logic [63:0] pos(input int idx, input int off);
    return {32'(off), 25'(idx), 7'h7f};
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input bit has_exp, input int addr);
    if (has_exp) exp_q.push_back({16'(addr), seq});
    @(negedge clk);
    in_valid = 1'b1; in_byte = seq;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
    seq = seq + 8'd7;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 256; k++) tbl[k] = '0;
    tbl[32]  = ent(16'h40, 0, 0, 1, 0, 0);  // table A @0x100
    tbl[33]  = ent(16'h48, 1, 0, 0, 0, 0);
    tbl[34]  = ent(16'h20, 0, 1, 0, 0, 0);  // link to B @0x200
    tbl[64]  = ent(16'h50, 0, 0, 0, 0, 0);  // table B
    tbl[65]  = ent(16'h10, 0, 1, 0, 0, 0);  // link back to A
    tbl[96]  = ent(16'h60, 0, 0, 1, 1, 0);  // table C @0x300: INT+STOP
    tbl[112] = ent(16'h10, 0, 1, 0, 0, 0);  // table D @0x380: END at index 0
    tbl[120] = ent(16'h60, 0, 0, 0, 0, 1);  // table E @0x3C0: reserved bit set

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 enable", 64'(trace_enable), 64'd0);
    check("R1 idle", 64'(walker_idle), 64'd1);
    check("R1 flags", {61'd0, stat_stopped, stat_error, stat_lost}, 64'd0);
    check("R1 position", position, 64'h7f);
    check("R1 no requests", {62'd0, mem_wr_valid, ent_req_valid}, 64'd0);
    check("R1 irq", 64'(irq), 64'd0);

    // ring walk: A e0 (INT), A e1, link to B, B e0, link back to A
    cfg(2'd1, 64'h100);
    cfg(2'd2, pos(0, 0));
    cfg(2'd0, 64'd1);
    for (int k = 0; k < 16; k++) send(1, 16'h400 + k);
    send(1, 16'h480);
    check("R5 index step", position, pos(1, 1));
    bp_mode = 1;
    for (int k = 1; k < 32; k++) send(1, 16'h480 + k);
    send(1, 16'h500);
    check("R6 chained base", 64'(table_base), 64'h200);
    for (int k = 1; k < 16; k++) send(1, 16'h500 + k);
    bp_mode = 0;
    for (int k = 0; k < 5; k++) send(1, 16'h400 + k);
    wait_cyc(2);
    check("R6 ring base", 64'(table_base), 64'h100);
    cfg(2'd1, 64'h300);
    cfg(2'd2, pos(2, 7));
    check("R2 base ignored while enabled", 64'(table_base), 64'h100);
    check("R2 position ignored while enabled", position, pos(0, 5));
    check("R8 irq count after INT region", 64'(irq_cnt), 64'd1);
    cfg(2'd0, 64'd0);
    wait_cyc(3);
    check("R12 idle after disable", 64'(walker_idle), 64'd1);

    // STOP region entered mid-way
    cfg(2'd1, 64'h300);
    cfg(2'd2, pos(0, 10));
    check("R2 position written while disabled", position, pos(0, 10));
    cfg(2'd0, 64'd1);
    for (int k = 10; k < 16; k++) send(1, 16'h600 + k);
    wait_cyc(3);
    check("R7 stopped", 64'(stat_stopped), 64'd1);
    check("R7 position held at size", position, pos(0, 16));
    check("R7 idle", 64'(walker_idle), 64'd1);
    check("R8 irq with STOP", 64'(irq_cnt), 64'd2);
    for (int k = 0; k < 3; k++) send(0, 0);
    wait_cyc(2);
    check("R11 lost while stopped", 64'(stat_lost), 64'd1);

    // clear status; restart at offset==size must flag an error
    cfg(2'd3, 64'd0);
    check("R10 flags cleared", {62'd0, stat_stopped, stat_lost}, 64'd0);
    wait_cyc(6);
    check("R9 offset beyond region", 64'(stat_error), 64'd1);
    check("R9 idle on error", 64'(walker_idle), 64'd1);
    cfg(2'd0, 64'd0);
    cfg(2'd3, 64'd0);

    // END at index 0
    cfg(2'd1, 64'h380);
    cfg(2'd2, pos(0, 0));
    cfg(2'd0, 64'd1);
    wait_cyc(6);
    check("R9 END at index 0", 64'(stat_error), 64'd1);
    cfg(2'd0, 64'd0);
    cfg(2'd3, 64'd0);
    // reserved bit set
    cfg(2'd1, 64'h3C0);
    cfg(2'd0, 64'd1);
    wait_cyc(6);
    check("R9 reserved bit", 64'(stat_error), 64'd1);
    cfg(2'd0, 64'd0);
    cfg(2'd3, 64'd0);
    check("R10 error cleared", 64'(stat_error), 64'd0);

    // disable while a fetch request is stalled
    req_rdy = 0;
    cfg(2'd1, 64'h100);
    cfg(2'd2, pos(0, 0));
    cfg(2'd0, 64'd1);
    wait_cyc(3);
    check("R12 busy while fetching", 64'(walker_idle), 64'd0);
    check("R4 input held off during fetch", 64'(in_ready), 64'd0);
    cfg(2'd0, 64'd0);
    wait_cyc(3);
    check("R12 fetch still outstanding", 64'(walker_idle), 64'd0);
    req_rdy = 1;
    wait_cyc(4);
    check("R12 idle after response", 64'(walker_idle), 64'd1);
    check("R3 fetch address index 0", 64'(last_req_addr), 64'h100);
    send(0, 0);
    wait_cyc(2);
    check("R11 lost while disabled", 64'(stat_lost), 64'd1);
    cfg(2'd3, 64'd0);

    // restart at index 1, offset 3
    cfg(2'd2, pos(1, 3));
    cfg(2'd0, 64'd1);
    wait_cyc(4);
    check("R3 fetch address base+8*index", 64'(last_req_addr), 64'h108);
    bp_mode = 1;
    send(1, 16'h483);
    send(1, 16'h484);
    bp_mode = 0;
    cfg(2'd0, 64'd0);
    wait_cyc(3);
    check("R4 position after two bytes", position, pos(1, 5));
    check("R5 all expected writes seen", 64'(exp_q.size()), 64'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule